// File: doc/BRIEF.md
# Prioritized Three-Buffer CAN Transmit Scheduler

This block holds three outgoing message slots for a CAN node. For each slot it keeps a pending flag, a 2-bit priority and an identifier tag. It decides which pending slot goes to the protocol engine next. Software marks a slot pending with a write strobe. A slot can also be triggered by an active-low request pin, once the pin has been synchronized and enabled for that use. When a pin is not enabled as a trigger, its synchronized level can still be read back as a plain input.

Toward the protocol engine the block uses a simple handshake. It raises a request and names the chosen slot together with its tag. The engine grants the request when the frame goes on the bus, and later reports one outcome: completed, lost arbitration or error. Each slot keeps sticky flags for aborted, lost arbitration and transmit error, and produces a one-cycle done pulse.

A pending slot can be withdrawn with an abort. An abort never cuts a frame that is already on the bus; it takes effect only if that frame fails. In single-attempt mode a slot is dropped after any unsuccessful attempt.

Top module: `can_tx_sched`

## Requirements
- R1: After reset the pending, aborted, lost and error flags are all 0, `done_irq` is 0, `eng_req` is low and `pin_level` is all ones.
- R2: A `req_set[i]` strobe on a non-pending slot sets `txreq[i]` at the next edge and clears `aborted[i]`, `lost[i]` and `txerr[i]`. On a slot that is already pending the strobe has no effect.
- R3: `rts_n[i]` passes through two synchronizing flops, and `pin_level[i]` shows its level two edges after it changes. When `pin_en[i]` is 1, a falling edge sets `txreq[i]` on the third edge after the pin drops, with the same flag clearing as R2. When `pin_en[i]` is 0, the pin starts nothing.
- R4: While idle, `eng_req` is high whenever any slot is pending. `eng_sel` then names the pending slot with the largest priority; on a tie the higher slot number wins. While idle with nothing pending, `eng_sel` reads 0. `eng_tag` always shows the tag of the slot named by `eng_sel`.
- R5: `eng_grant` sampled while `eng_req` is high makes the selected slot active. `eng_req` then stays low and `eng_sel` keeps naming that slot until an outcome arrives.
- R6: `eng_done` for the active slot clears its `txreq` and pulses `done_irq[i]` for exactly one cycle, starting at the same edge. The block then returns to idle.
- R7: `eng_lost` for the active slot sets `lost[i]`. Outside single-attempt mode (`one_shot`=0) the slot stays pending and is selected again. With `one_shot`=1 its `txreq` is cleared.
- R8: `eng_err` for the active slot sets `txerr[i]`. The slot is kept or dropped by the same rule as R7.
- R9: An abort of a slot that is pending but not on the bus clears `txreq[i]` and sets `aborted[i]` at the next edge. An abort of a slot that is not pending changes nothing.
- R10: An abort of the active slot does not end the attempt. If the attempt completes, `aborted[i]` stays 0. If it loses arbitration or fails, `txreq[i]` is cleared and `aborted[i]` is set, whatever the mode. An abort counts when it arrives at any time from the grant edge up to and including the outcome cycle.
- R11: Outcome inputs are ignored while no slot is active. When several outcome inputs are raised together, done takes precedence over error, and error over lost.
- R12: A grant and an abort of the selected slot in the same cycle: the grant is taken, and the abort is held for that attempt as in R10.
- R13: `prio_we[i]` writes `prio_wdata` into slot i's priority, and `tag_we[i]` writes `tag_wdata` into its tag. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| one_shot | input | 1 | Single-attempt mode |
| req_set | input | NBUF | Per-slot request strobe from the register side |
| abort_set | input | NBUF | Per-slot abort strobe |
| pin_en | input | NBUF | Use the matching request pin as a trigger |
| rts_n | input | NBUF | Active-low request pins, asynchronous |
| prio_we | input | NBUF | Per-slot priority write enable |
| prio_wdata | input | PRIO_W | Priority write data |
| tag_we | input | NBUF | Per-slot tag write enable |
| tag_wdata | input | TAG_W | Tag write data |
| eng_req | output | 1 | Request to the protocol engine |
| eng_sel | output | SEL_W | Selected or active slot |
| eng_tag | output | TAG_W | Tag of the slot on `eng_sel` |
| eng_grant | input | 1 | Engine starts the selected frame |
| eng_done | input | 1 | Active frame completed |
| eng_lost | input | 1 | Active frame lost arbitration |
| eng_err | input | 1 | Active frame ended in error |
| txreq | output | NBUF | Pending flags |
| aborted | output | NBUF | Aborted flags |
| lost | output | NBUF | Lost-arbitration flags |
| txerr | output | NBUF | Transmit-error flags |
| done_irq | output | NBUF | One-cycle completion pulses |
| pin_level | output | NBUF | Synchronized request-pin levels |

## Verification
The collision that matters most is an abort landing in the same cycle as the grant of that slot, or in the same cycle as its outcome. Both are provoked on purpose: an abort is raised together with `eng_grant`, and an abort together with `eng_lost` or `eng_err`. The bench then checks that the frame was granted anyway, and that `aborted` follows only a failed attempt. A long random phase raises request, abort, grant and outcome strobes independently. A behavioural model judges every cycle, so request-versus-abort, grant-versus-new-request and multi-outcome cases arise with every combination of phase.

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int NBUF   = 3,
  parameter int PRIO_W = 2,
  parameter int TAG_W  = 11,
  localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              one_shot,
  input  logic [NBUF-1:0]   req_set,
  input  logic [NBUF-1:0]   abort_set,
  input  logic [NBUF-1:0]   pin_en,
  input  logic [NBUF-1:0]   rts_n,
  input  logic [NBUF-1:0]   prio_we,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic [NBUF-1:0]   tag_we,
  input  logic [TAG_W-1:0]  tag_wdata,
  output logic              eng_req,
  output logic [SEL_W-1:0]  eng_sel,
  output logic [TAG_W-1:0]  eng_tag,
  input  logic              eng_grant,
  input  logic              eng_done,
  input  logic              eng_lost,
  input  logic              eng_err,
  output logic [NBUF-1:0]   txreq,
  output logic [NBUF-1:0]   aborted,
  output logic [NBUF-1:0]   lost,
  output logic [NBUF-1:0]   txerr,
  output logic [NBUF-1:0]   done_irq,
  output logic [NBUF-1:0]   pin_level
);

  logic [NBUF-1:0]   s1, s2, s3, abt_pend;
  logic              busy;
  logic [SEL_W-1:0]  act, win;
  logic [PRIO_W-1:0] win_p;
  logic              any;
  logic [PRIO_W-1:0] prio [NBUF];
  logic [TAG_W-1:0]  tag  [NBUF];

  always_comb begin
    win   = '0;
    win_p = '0;
    any   = 1'b0;
    for (int i = 0; i < NBUF; i++)
      if (txreq[i] && (!any || prio[i] >= win_p)) begin
        win   = SEL_W'(i);
        win_p = prio[i];
        any   = 1'b1;
      end
  end

  assign eng_req   = !busy && any;
  assign eng_sel   = busy ? act : win;
  assign eng_tag   = tag[eng_sel];
  assign pin_level = s2;

  wire take     = eng_req && eng_grant;
  wire fin      = busy && (eng_done || eng_lost || eng_err);
  wire ok_done  = busy && eng_done;
  wire bad_err  = busy && !eng_done && eng_err;
  wire bad_lost = busy && !eng_done && !eng_err && eng_lost;

  logic [NBUF-1:0] fall, is_act, newreq, kill, ab_eff, taken;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      fall[i]   = s3[i] && !s2[i] && pin_en[i];
      is_act[i] = busy && (act == SEL_W'(i));
      taken[i]  = take && (win == SEL_W'(i));
      newreq[i] = (req_set[i] || fall[i]) && !txreq[i];
      kill[i]   = abort_set[i] && txreq[i] && !is_act[i] && !taken[i];
      ab_eff[i] = abt_pend[i] || abort_set[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= rts_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      act  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      act  <= win;
    end else if (fin) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreq    <= '0;
      aborted  <= '0;
      lost     <= '0;
      txerr    <= '0;
      done_irq <= '0;
      abt_pend <= '0;
      for (int i = 0; i < NBUF; i++) begin
        prio[i] <= '0;
        tag[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        done_irq[i] <= is_act[i] && ok_done;
        if (prio_we[i]) prio[i] <= prio_wdata;
        if (tag_we[i])  tag[i]  <= tag_wdata;

        if (is_act[i] && !fin)  abt_pend[i] <= ab_eff[i];
        else if (taken[i])      abt_pend[i] <= abort_set[i];
        else                    abt_pend[i] <= 1'b0;

        if (newreq[i]) begin
          txreq[i]   <= 1'b1;
          aborted[i] <= 1'b0;
          lost[i]    <= 1'b0;
          txerr[i]   <= 1'b0;
        end else if (kill[i]) begin
          txreq[i]   <= 1'b0;
          aborted[i] <= 1'b1;
        end else if (is_act[i]) begin
          if (ok_done) begin
            txreq[i] <= 1'b0;
          end else if (bad_err || bad_lost) begin
            if (bad_err)  txerr[i] <= 1'b1;
            if (bad_lost) lost[i]  <= 1'b1;
            if (one_shot || ab_eff[i]) txreq[i]   <= 1'b0;
            if (ab_eff[i])             aborted[i] <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
  parameter int NBUF  = 3,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [NBUF-1:0]  req_set,
  input logic [NBUF-1:0]  pin_en,
  input logic             eng_req,
  input logic [SEL_W-1:0] eng_sel,
  input logic             eng_grant,
  input logic             eng_done,
  input logic             eng_lost,
  input logic             eng_err,
  input logic [NBUF-1:0]  txreq,
  input logic [NBUF-1:0]  aborted,
  input logic [NBUF-1:0]  lost,
  input logic [NBUF-1:0]  txerr,
  input logic [NBUF-1:0]  done_irq
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (txreq == '0 && aborted == '0 && lost == '0 &&
                      txerr == '0 && done_irq == '0 && !eng_req));

  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_set & ~txreq) != '0) |=>
      (((($past(req_set) & ~$past(txreq)) & ~txreq) == '0) &&
       ((($past(req_set) & ~$past(txreq)) & aborted) == '0)));

  a_r4_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> txreq[eng_sel]);

  a_r5_hold_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_grant) |=> (!eng_req && busy && $stable(eng_sel)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done_irq) <= 1);

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> ($countones(done_irq) == 1 && (done_irq & txreq) == '0));

  a_r11_idle_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (eng_done || eng_lost || eng_err) && req_set == '0 && pin_en == '0)
      |=> ($stable(lost) && $stable(txerr) && done_irq == '0));

endmodule

bind can_tx_sched can_tx_sched_chk #(.NBUF(NBUF), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/can_tx_sched_bench.sv
`timescale 1ns/1ps
module can_tx_sched_bench;
  localparam int NB = 3;
  localparam int PW = 2;
  localparam int TW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic one_shot = 1'b0;
  logic [NB-1:0] req_set = '0, abort_set = '0, pin_en = '0, rts_n = '1;
  logic [NB-1:0] prio_we = '0, tag_we = '0;
  logic [PW-1:0] prio_wdata = '0;
  logic [TW-1:0] tag_wdata = '0;
  logic eng_grant = 1'b0, eng_done = 1'b0, eng_lost = 1'b0, eng_err = 1'b0;
  logic eng_req;
  logic [1:0] eng_sel;
  logic [TW-1:0] eng_tag;
  logic [NB-1:0] txreq, aborted, lost, txerr, done_irq, pin_level;

  always #2.5 clk = ~clk;

  can_tx_sched #(.NBUF(NB), .PRIO_W(PW), .TAG_W(TW)) u_can_tx_sched (
    .clk(clk), .rst_n(rst_n), .one_shot(one_shot),
    .req_set(req_set), .abort_set(abort_set), .pin_en(pin_en), .rts_n(rts_n),
    .prio_we(prio_we), .prio_wdata(prio_wdata), .tag_we(tag_we), .tag_wdata(tag_wdata),
    .eng_req(eng_req), .eng_sel(eng_sel), .eng_tag(eng_tag),
    .eng_grant(eng_grant), .eng_done(eng_done), .eng_lost(eng_lost), .eng_err(eng_err),
    .txreq(txreq), .aborted(aborted), .lost(lost), .txerr(txerr),
    .done_irq(done_irq), .pin_level(pin_level));

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // behavioural reference model
  bit m_tx[NB], m_ab[NB], m_lo[NB], m_er[NB], m_dn[NB], m_pd[NB];
  bit m_s1[NB], m_s2[NB], m_s3[NB];
  int m_prio[NB], m_tag[NB];
  bit m_busy;
  int m_act;

  function automatic int m_pick();
    int best = -1;
    int bp = -1;
    for (int i = NB - 1; i >= 0; i--)
      if (m_tx[i] && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
    return (best < 0) ? 0 : best;
  endfunction

  function automatic bit m_any();
    bit a = 1'b0;
    for (int i = 0; i < NB; i++) a |= m_tx[i];
    return a;
  endfunction

  function automatic logic [NB-1:0] pk(input bit a[NB]);
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = a[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_tx[i] = 0; m_ab[i] = 0; m_lo[i] = 0; m_er[i] = 0; m_dn[i] = 0; m_pd[i] = 0;
        m_s1[i] = 1; m_s2[i] = 1; m_s3[i] = 1; m_prio[i] = 0; m_tag[i] = 0;
      end
      m_busy = 0;
      m_act = 0;
    end else begin
      int w;
      bit take, fin;
      bit fl[NB];
      w = m_pick();
      take = !m_busy && m_any() && eng_grant;
      fin = m_busy && (eng_done || eng_lost || eng_err);
      for (int i = 0; i < NB; i++) fl[i] = m_s3[i] && !m_s2[i] && pin_en[i];
      for (int i = 0; i < NB; i++) begin
        bit a_i, ab;
        a_i = m_busy && m_act == i;
        ab = m_pd[i] || abort_set[i];
        m_dn[i] = 0;
        if (!m_tx[i]) begin
          if (req_set[i] || fl[i]) begin
            m_tx[i] = 1; m_ab[i] = 0; m_lo[i] = 0; m_er[i] = 0;
          end
        end else if (a_i) begin
          if (eng_done) begin
            m_tx[i] = 0; m_dn[i] = 1;
          end else if (eng_err || eng_lost) begin
            if (eng_err) m_er[i] = 1; else m_lo[i] = 1;
            if (one_shot || ab) m_tx[i] = 0;
            if (ab) m_ab[i] = 1;
          end
        end else if (abort_set[i] && !(take && w == i)) begin
          m_tx[i] = 0; m_ab[i] = 1;
        end
        if (a_i && !fin) m_pd[i] = ab;
        else if (take && w == i) m_pd[i] = abort_set[i];
        else m_pd[i] = 0;
        if (prio_we[i]) m_prio[i] = prio_wdata;
        if (tag_we[i]) m_tag[i] = tag_wdata;
      end
      if (take) begin m_busy = 1; m_act = w; end
      else if (fin) m_busy = 0;
      for (int i = 0; i < NB; i++) begin
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = rts_n[i];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      int sel;
      sel = m_busy ? m_act : m_pick();
      chk("R2 R3 R6 R7 R8 R9 R10 R12", "txreq", txreq, pk(m_tx));
      chk("R9 R10 R12", "aborted", aborted, pk(m_ab));
      chk("R7 R11", "lost", lost, pk(m_lo));
      chk("R8 R11", "txerr", txerr, pk(m_er));
      chk("R6 R11", "done_irq", done_irq, pk(m_dn));
      chk("R4 R5", "eng_req", eng_req, !m_busy && m_any());
      chk("R4 R5", "eng_sel", eng_sel, sel);
      chk("R4 R13", "eng_tag", eng_tag, m_tag[sel]);
      chk("R3", "pin_level", pin_level, pk(m_s2));
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic clr();
    req_set = '0; abort_set = '0; prio_we = '0; tag_we = '0;
    eng_grant = 0; eng_done = 0; eng_lost = 0; eng_err = 0;
  endtask

  task automatic report();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    tick(); tick();
    cmp_on = 1'b1;
    chk("R1", "txreq in reset", txreq, 0);
    chk("R1", "pin_level in reset", pin_level, 3'b111);
    tick(); rst_n = 1'b1; tick();
    chk("R1", "eng_req after reset", eng_req, 0);

    // R13 priorities and tags
    prio_we = 3'b001; prio_wdata = 1; tick(); clr();
    prio_we = 3'b110; prio_wdata = 3; tick(); clr();
    tag_we = 3'b001; tag_wdata = 11'h100; tick(); clr();
    tag_we = 3'b010; tag_wdata = 11'h2A5; tick(); clr();
    tag_we = 3'b100; tag_wdata = 11'h7FF; tick(); clr();

    req_set = 3'b111; tick(); clr();
    chk("R4", "tie to higher slot", eng_sel, 2);
    chk("R13", "tag of slot 2", eng_tag, 11'h7FF);
    eng_grant = 1; tick(); clr();
    chk("R5", "eng_req after grant", eng_req, 0);
    eng_done = 1; tick(); clr();
    chk("R6", "txreq after done", txreq, 3'b011);
    chk("R6", "done pulse", done_irq, 3'b100);
    tick();
    chk("R6", "pulse one cycle", done_irq, 0);
    chk("R4", "next winner", eng_sel, 1);
    eng_grant = 1; tick(); clr();
    eng_lost = 1; tick(); clr();
    chk("R7", "requeued after lost", txreq, 3'b011);
    chk("R7", "lost flag", lost, 3'b010);
    eng_grant = 1; tick(); clr();
    eng_err = 1; tick(); clr();
    chk("R8", "requeued after error", txreq, 3'b011);
    chk("R8", "error flag", txerr, 3'b010);
    eng_grant = 1; tick(); clr();
    eng_done = 1; tick(); clr();
    eng_grant = 1; tick(); clr();
    eng_done = 1; tick(); clr();
    chk("R6", "all sent", txreq, 0);

    req_set = 3'b010; tick(); clr();
    chk("R2", "flags cleared by new request", {lost[1], txerr[1]}, 0);

    one_shot = 1;
    eng_grant = 1; tick(); clr();
    eng_lost = 1; tick(); clr();
    chk("R7", "one-shot drop on lost", txreq, 0);
    req_set = 3'b001; tick(); clr();
    eng_grant = 1; tick(); clr();
    eng_err = 1; tick(); clr();
    chk("R8", "one-shot drop on error", txreq, 0);
    chk("R8", "one-shot error flag", txerr[0], 1);
    one_shot = 0;

    req_set = 3'b110; tick(); clr();
    abort_set = 3'b010; tick(); clr();
    chk("R9", "abort pending slot", txreq, 3'b100);
    chk("R9", "aborted flag", aborted[1], 1);
    abort_set = 3'b001; tick(); clr();
    chk("R9", "abort of idle slot ignored", {aborted[0], txreq}, 4'b0100);

    eng_grant = 1; tick(); clr();
    abort_set = 3'b100; tick(); clr();
    chk("R10", "frame not cut", txreq, 3'b100);
    eng_done = 1; tick(); clr();
    chk("R10", "completed despite abort", {aborted[2], done_irq}, 4'b0100);
    req_set = 3'b100; tick(); clr();
    eng_grant = 1; tick(); clr();
    abort_set = 3'b100; eng_err = 1; tick(); clr();
    chk("R10", "abort with error", {txreq[2], aborted[2], txerr[2]}, 3'b011);

    req_set = 3'b001; tick(); clr();
    eng_grant = 1; abort_set = 3'b001; tick(); clr();
    chk("R12", "grant taken over abort", {txreq[0], aborted[0], eng_req}, 3'b100);
    eng_lost = 1; tick(); clr();
    chk("R12", "held abort applied", {txreq[0], aborted[0], lost[0]}, 3'b011);

    eng_done = 1; eng_lost = 1; eng_err = 1; tick(); clr();
    chk("R11", "idle outcome ignored", done_irq, 0);
    req_set = 3'b010; tick(); clr();
    eng_grant = 1; tick(); clr();
    eng_done = 1; eng_lost = 1; eng_err = 1; tick(); clr();
    chk("R11", "done wins", {done_irq, lost[1], txerr[1], txreq[1]}, 6'b010000);

    pin_en = 3'b001; rts_n = 3'b110; tick(); tick();
    chk("R3", "synced level", pin_level, 3'b110);
    chk("R3", "not yet requested", txreq[0], 0);
    tick();
    chk("R3", "pin request", txreq[0], 1);
    eng_grant = 1; tick(); clr();
    eng_done = 1; tick(); clr();
    pin_en = 3'b000; rts_n = 3'b100; tick(); tick(); tick(); tick();
    chk("R3", "disabled pin", txreq, 0);
    chk("R3", "pin read back", pin_level, 3'b100);
    rts_n = 3'b111; tick(); tick(); tick();

    for (int c = 0; c < 4000; c++) begin
      clr();
      req_set   = ($urandom % 4 == 0) ? NB'($urandom) : '0;
      abort_set = ($urandom % 6 == 0) ? NB'($urandom) : '0;
      if ($urandom % 8 == 0) begin prio_we = NB'($urandom); prio_wdata = PW'($urandom); end
      if ($urandom % 8 == 0) begin tag_we = NB'($urandom); tag_wdata = TW'($urandom); end
      if ($urandom % 50 == 0) one_shot = ~one_shot;
      if ($urandom % 10 == 0) pin_en = NB'($urandom);
      if ($urandom % 5 == 0) rts_n = NB'($urandom);
      if (!m_busy) begin
        eng_grant = ($urandom % 3 == 0);
        if ($urandom % 10 == 0) begin eng_done = $urandom; eng_lost = $urandom; eng_err = $urandom; end
      end else if ($urandom % 3 == 0) begin
        eng_done = $urandom; eng_lost = $urandom; eng_err = $urandom;
      end
      tick();
    end
    clr();
    tick();
    report();
  end
endmodule